// File: doc/BRIEF.md
# Single-Level Page Table Address Translator

This block maps a 32-bit virtual address to a physical address using one page table held in ordinary memory. The address splits at a 4 KB page boundary. The low 12 bits are the byte offset inside the page, and they pass through unchanged. The upper 20 bits are the virtual page number, which selects one 4-byte entry of the current process's table. The table starts at a loadable base address. A loadable length value says how many entries the process currently owns.

A translation starts with a request on the CPU-side valid/ready port. The block first compares the page number with the length. A page number at or past the length is refused at once, and memory is not read. Otherwise the block issues one word read at `base + 4 * page_number` over a valid/ready request channel and waits for the returned word. The memory side must return that word at least one cycle after it accepts the request.

The response carries a physical address and a 2-bit status. If the entry is marked present, the address is the entry's frame number joined to the original offset. If the entry is marked absent, the block reports a page fault. Only one translation is in flight at a time. The base and length values can be reloaded only while the block is idle.

Top module: `pt_xlate`

## Requirements
- R1: A translation whose entry has bit 31 set returns status 2'b00 and a physical address equal to {entry bits 19:0, virtual address bits 11:0}.
- R2: For a page number inside the table, the block makes exactly one memory read, at address base + 4 * page_number (modulo 2^32).
- R3: A page number greater than or equal to the length value returns status 2'b10 with physical address 0, and no memory read is issued for that translation.
- R4: A translation whose entry has bit 31 clear returns status 2'b01 (page fault) with physical address 0.
- R5: Entry bits 30:20 do not affect the result.
- R6: `req_ready` is low from the cycle after a request is accepted until the response has been taken, so only one request is held at a time.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response stays valid and its address and status do not change.
- R8: Writes to the base or length value are ignored while a translation is in progress, and take effect when made while idle.
- R9: After reset the block is idle (`req_ready` high, `rsp_valid` and `mem_req_valid` low) and the length value is 0, so every translation returns status 2'b10.
- R10: Once raised, `mem_req_valid` stays high with a stable `mem_req_addr` until the memory accepts the request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_paddr | output | 32 | Physical address, 0 on any refusal |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 length violation |
| mem_req_valid | output | 1 | Entry read request present |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned (at least one cycle after acceptance) |
| mem_rsp_data | input | 32 | Table entry word |
| cfg_base_we | input | 1 | Load the table base |
| cfg_base | input | 32 | New table base address |
| cfg_len_we | input | 1 | Load the table length |
| cfg_len | input | 21 | New table length in entries (0 to 2^20) |

## Verification
The bench sweeps every page number around a small table length. This catches an off-by-one at the boundary, where a `>` compare in place of `>=` would read one entry past the table and return a frame instead of status 10. Entries mix present and absent bits with junk in bits 30:20. A design that decoded the wrong valid bit or leaked the junk bits into the frame would return wrong addresses. Each memory address is compared with base plus four times the page number, which catches a missing word scaling. Lengths of 0, 1 and the full 2^20 are tried. Configuration writes are made in the middle of a translation. A design that accepted them would read from the wrong base or refuse a later in-range page.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_CHECK   = 2'd1,
    ST_READ    = 2'd2,
    ST_RESPOND = 2'd3
  } xl_state_e;

  typedef enum logic [1:0] {
    XS_OK     = 2'b00,
    XS_PFAULT = 2'b01,
    XS_LENVIO = 2'b10
  } xl_status_e;

endpackage

// File: rtl/pt_rst_sync.sv
module pt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/pt_cfg_regs.sv
module pt_cfg_regs #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_open,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_in,
  input  logic              len_we,
  input  logic [LEN_W-1:0]  len_in,
  output logic [ADDR_W-1:0] base_q,
  output logic [LEN_W-1:0]  len_q
);
  logic              base_en, len_en;
  logic [ADDR_W-1:0] base_d;
  logic [LEN_W-1:0]  len_d;

  always_comb begin
    base_en = load_open && base_we;
    len_en  = load_open && len_we;
    base_d  = base_in;
    len_d   = len_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      if (base_en) base_q <= base_d;
      if (len_en)  len_q  <= len_d;
    end
  end
endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20,
  parameter int PTE_W     = 32,
  parameter int ADDR_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VA_W-1:0]            req_vaddr,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [ADDR_W-1:0]          mem_req_addr,
  input  logic                       mem_rsp_valid,
  input  logic [PTE_W-1:0]           mem_rsp_data,
  input  logic [ADDR_W-1:0]          base_q,
  input  logic [VA_W-PAGE_BITS:0]    len_q,
  output logic                       cfg_open,
  output logic [VA_W-1:0]            vaddr_q,
  output logic                       len_fail_q,
  output logic                       present_q,
  output logic [FRAME_W-1:0]         frame_q
);
  localparam int VPN_W     = VA_W - PAGE_BITS;
  localparam int LEN_W     = VPN_W + 1;
  localparam int PTE_SHIFT = $clog2(PTE_W / 8);
  localparam int VALID_BIT = PTE_W - 1;

  xl_state_e        state_q, state_d;
  logic [VPN_W-1:0] vpn;
  logic             over_len;
  logic             va_en, lf_en, pte_en, mem_hs;
  logic             issued_q, issued_d;
  logic             unused_pte_bits;

  assign unused_pte_bits = ^mem_rsp_data[VALID_BIT-1:FRAME_W];

  always_comb begin
    vpn      = vaddr_q[VA_W-1:PAGE_BITS];
    over_len = ({1'b0, vpn} >= LEN_W'(len_q));
    mem_req_addr = base_q + (ADDR_W'(vpn) << PTE_SHIFT);
  end

  always_comb begin
    req_ready     = (state_q == ST_IDLE);
    cfg_open      = (state_q == ST_IDLE);
    rsp_valid     = (state_q == ST_RESPOND);
    mem_req_valid = (state_q == ST_READ) && !issued_q;
    mem_hs        = mem_req_valid && mem_req_ready;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (req_valid) state_d = ST_CHECK;
      ST_CHECK:   state_d = over_len ? ST_RESPOND : ST_READ;
      ST_READ:    if (issued_q && mem_rsp_valid) state_d = ST_RESPOND;
      ST_RESPOND: if (rsp_ready) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    va_en    = (state_q == ST_IDLE) && req_valid;
    lf_en    = (state_q == ST_CHECK);
    pte_en   = (state_q == ST_READ) && issued_q && mem_rsp_valid;
    issued_d = (state_d == ST_READ) && (issued_q || mem_hs);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      issued_q   <= 1'b0;
      vaddr_q    <= '0;
      len_fail_q <= 1'b0;
      present_q  <= 1'b0;
      frame_q    <= '0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
      if (va_en)  vaddr_q    <= req_vaddr;
      if (lf_en)  len_fail_q <= over_len;
      if (pte_en) begin
        present_q <= mem_rsp_data[VALID_BIT];
        frame_q   <= mem_rsp_data[FRAME_W-1:0];
      end
    end
  end
endmodule

// File: rtl/pt_resp_fmt.sv
module pt_resp_fmt
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20
) (
  input  logic [VA_W-1:0]              vaddr_q,
  input  logic                         len_fail_q,
  input  logic                         present_q,
  input  logic [FRAME_W-1:0]           frame_q,
  output logic [FRAME_W+PAGE_BITS-1:0] paddr,
  output logic [1:0]                   status
);
  logic unused_vpn_bits;
  assign unused_vpn_bits = ^vaddr_q[VA_W-1:PAGE_BITS];

  always_comb begin
    if (len_fail_q) begin
      status = XS_LENVIO;
      paddr  = '0;
    end else if (!present_q) begin
      status = XS_PFAULT;
      paddr  = '0;
    end else begin
      status = XS_OK;
      paddr  = {frame_q, vaddr_q[PAGE_BITS-1:0]};
    end
  end
endmodule

// File: rtl/pt_xlate.sv
module pt_xlate #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20,
  parameter int PTE_W     = 32,
  parameter int MEM_AW    = 32,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int LEN_W    = VPN_W + 1,
  localparam int PA_W     = FRAME_W + PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_status,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  input  logic              cfg_base_we,
  input  logic [MEM_AW-1:0] cfg_base,
  input  logic              cfg_len_we,
  input  logic [LEN_W-1:0]  cfg_len
);
  logic               rst_sync_n;
  logic               cfg_open;
  logic [MEM_AW-1:0]  base_q;
  logic [LEN_W-1:0]   len_q;
  logic [VA_W-1:0]    vaddr_q;
  logic               len_fail_q, present_q;
  logic [FRAME_W-1:0] frame_q;

  pt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pt_cfg_regs #(.ADDR_W(MEM_AW), .LEN_W(LEN_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load_open (cfg_open),
    .base_we   (cfg_base_we),
    .base_in   (cfg_base),
    .len_we    (cfg_len_we),
    .len_in    (cfg_len),
    .base_q    (base_q),
    .len_q     (len_q)
  );

  pt_ctrl #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W),
    .PTE_W(PTE_W), .ADDR_W(MEM_AW)
  ) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .base_q        (base_q),
    .len_q         (len_q),
    .cfg_open      (cfg_open),
    .vaddr_q       (vaddr_q),
    .len_fail_q    (len_fail_q),
    .present_q     (present_q),
    .frame_q       (frame_q)
  );

  pt_resp_fmt #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W)) u_fmt (
    .vaddr_q    (vaddr_q),
    .len_fail_q (len_fail_q),
    .present_q  (present_q),
    .frame_q    (frame_q),
    .paddr      (rsp_paddr),
    .status     (rsp_status)
  );
endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  parameter int MEM_AW = 32,
  parameter int PAGE_BITS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [1:0]        rsp_status,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [MEM_AW-1:0] mem_req_addr
);
  logic [VA_W-1:0] seen_va_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_va_q <= '0;
    else if (req_valid && req_ready) seen_va_q <= req_vaddr;
  end

  // R1: offset bits of an ok response match the accepted request
  p_offset_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b00) |-> rsp_paddr[PAGE_BITS-1:0] == seen_va_q[PAGE_BITS-1:0]);

  // R1: only the three defined status codes appear
  p_status_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_status != 2'b11);

  // R3: length violation reports a zero address
  p_lenvio_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b10) |-> rsp_paddr == '0);

  // R4: page fault reports a zero address
  p_fault_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'b01) |-> rsp_paddr == '0);

  // R6: no new request accepted while a response is pending
  p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> !req_ready);

  // R7: a stalled response holds its contents
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)));

  // R10: a stalled memory request holds its address
  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind pt_xlate pt_xlate_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .MEM_AW(MEM_AW), .PAGE_BITS(PAGE_BITS)
) u_chk (.*);

// File: tb/sim_pt_xlate.sv
`timescale 1ns/1ps
module sim_pt_xlate;
  localparam logic [31:0] BASE_A = 32'h0004_0100;
  localparam logic [31:0] BASE_B = 32'h0010_2000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid, rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_status;
  logic        mem_req_valid, mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        cfg_base_we = 1'b0, cfg_len_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [20:0] cfg_len = '0;

  int checks = 0, errs = 0, cyc = 0, reads_seen = 0;
  logic [31:0] exp_base = 32'h0, exp_addr = 32'h0;

  always #5 clk = ~clk;

  pt_xlate u0 (.*);

  function automatic logic [31:0] gen_pte(input logic [31:0] idx);
    logic [19:0] fr;
    logic [10:0] junk;
    fr   = 20'((idx * 32'd2654435) + 32'd7);
    junk = 11'(idx * 32'd13 + 32'd5);
    return {(idx % 3) != 0, junk, fr};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // memory model: ready 3 cycles of 4, data two cycles after acceptance
  logic [7:0]  rc = '0;
  logic        s1_v = 1'b0;
  logic [31:0] s1_a = '0;
  assign mem_req_ready = (rc[1:0] != 2'b11);

  always @(posedge clk) begin
    rc <= rc + 8'd1;
    s1_v <= mem_req_valid && mem_req_ready;
    if (mem_req_valid && mem_req_ready) begin
      s1_a <= mem_req_addr;
      reads_seen++;
      chk(mem_req_addr == exp_addr, "R2 entry address", mem_req_addr, exp_addr);
    end
    mem_rsp_valid <= s1_v;
    mem_rsp_data  <= gen_pte((s1_a - exp_base) >> 2);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      $display("FAIL R6 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic set_cfg(input logic [31:0] b, input logic [20:0] l);
    @(negedge clk);
    cfg_base_we = 1'b1; cfg_base = b;
    cfg_len_we  = 1'b1; cfg_len  = l;
    @(negedge clk);
    cfg_base_we = 1'b0; cfg_len_we = 1'b0;
    exp_base = b;
  endtask

  task automatic xlate(input logic [31:0] va, input logic [20:0] len, input int hold);
    logic [19:0] vpn;
    logic [31:0] pte, ep;
    logic [1:0]  es;
    logic [31:0] cap_p;
    logic [1:0]  cap_s;
    int          er;
    bit          busy_low;
    vpn = va[31:12];
    pte = gen_pte({12'h0, vpn});
    if ({1'b0, vpn} >= len) begin es = 2'b10; ep = 0; er = 0; end
    else if (!pte[31])      begin es = 2'b01; ep = 0; er = 1; end
    else begin es = 2'b00; ep = {pte[19:0], va[11:0]}; er = 1; end
    exp_addr = exp_base + {10'h0, vpn, 2'b00};
    @(negedge clk);
    reads_seen = 0;
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0; req_vaddr = ~va;
    busy_low = 1'b1;
    while (!rsp_valid) begin
      if (req_ready) busy_low = 1'b0;
      @(negedge clk);
    end
    if (req_ready) busy_low = 1'b0;
    chk(rsp_status == es, "R1/R3/R4 status", {30'h0, rsp_status}, {30'h0, es});
    chk(rsp_paddr == ep, "R1/R4/R5 paddr", rsp_paddr, ep);
    chk(reads_seen == er, "R2/R3 read count", reads_seen, er);
    chk(busy_low, "R6 req_ready low while busy", {31'h0, busy_low}, 32'h1);
    if (hold > 0) begin
      cap_p = rsp_paddr; cap_s = rsp_status;
      repeat (hold) @(negedge clk);
      chk(rsp_valid && rsp_paddr == cap_p && rsp_status == cap_s, "R7 hold",
          rsp_paddr, cap_p);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R6 back to idle", {30'h0, rsp_valid, req_ready}, 32'h1);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9: idle outputs after reset
    chk(req_ready && !rsp_valid && !mem_req_valid, "R9 reset state",
        {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);
    // R9: length starts at 0, so everything is refused
    xlate(32'h0000_0123, 21'd0, 0);
    xlate(32'hFFFF_FFFF, 21'd0, 1);

    // sweep around a 40-entry table: R1 R2 R3 R4 R5 R7
    set_cfg(BASE_A, 21'd40);
    for (int v = 0; v < 48; v++)
      xlate({20'(v), 12'(v * 157 + 3)}, 21'd40, v % 3);
    xlate(32'h0008_0ABC, 21'd40, 0);

    // R3 boundary with length 1
    set_cfg(BASE_A, 21'd1);
    xlate(32'h0000_0FFF, 21'd1, 0);
    xlate(32'h0000_1000, 21'd1, 0);

    // R3 full-size table: top page is in range
    set_cfg(BASE_A, 21'h100000);
    xlate(32'hFFFF_F5A5, 21'h100000, 0);
    xlate(32'hFFFF_E001, 21'h100000, 2);

    // R8: loads during a translation are ignored
    set_cfg(BASE_A, 21'd10);
    fork
      xlate(32'h0000_5111, 21'd10, 6);
      begin
        repeat (2) @(negedge clk);
        cfg_base_we = 1'b1; cfg_base = 32'hDEAD_0000;
        cfg_len_we  = 1'b1; cfg_len  = 21'd0;
        repeat (3) @(negedge clk);
        cfg_base_we = 1'b0; cfg_len_we = 1'b0;
      end
    join
    xlate(32'h0000_9222, 21'd10, 0);   // R8: old length 10 still applies
    xlate(32'h0000_A222, 21'd10, 0);

    // R8: loads while idle take effect
    set_cfg(BASE_B, 21'd5);
    xlate(32'h0000_4333, 21'd5, 0);
    xlate(32'h0000_9333, 21'd5, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule